// File: doc/BRIEF.md
# Mailbox-Window Transmit and Receive Message Queues

This block holds two small message queues, one for frames waiting to go out and one for frames that have come in, and lets a host reach them only through two mailbox-shaped register windows. The host builds an outgoing frame in the transmit window (identifier word, length, eight data bytes). It then writes the value 0xFF to the transmit pointer register, which copies the window into the next free queue slot. The receive window always shows the oldest frame still held. Writing 0xFF to the receive pointer register throws that frame away and brings the next one into view.

On the bus side, a frame transmitter takes entries from a valid/pop port, and a frame receiver hands in complete frames on a push port together with a 16-bit timestamp. The block reports how many transmit entries are still unsent and whether the receive queue is empty. It keeps three sticky event flags: transmit taken, frame received and receive overrun. Each flag has its own enable, and together they drive one interrupt line. When the receive queue is full, a configuration bit chooses between replacing the newest stored frame and dropping the incoming one.

The register file is 32 bits wide and word addressed: 0 to 3 are the transmit window (ID, length, data bytes 0-3, data bytes 4-7), 4 to 7 are the receive window in the same layout, 8 is transmit control, 9 is receive control, 10 is the transmit pointer, 11 is the receive pointer, 12 is the flag enable register and 13 is the flag register. Data byte k of a frame sits at bits 8k+7:8k of the two data words, with byte 0 in bits 7:0 of the low word. The receive length word carries the data length code in bits 3:0 and the timestamp in bits 31:16, with the high byte in bits 31:24. In the ID word, bit 31 marks an extended identifier and bit 30 marks a remote request. The block stores the ID word whole and does not interpret it.

Top module: `mbox_fifo_pair`

## Requirements
- R1: After reset both queues are disabled and empty. Transmit control reads 0x0, receive control reads 0x80, the flag register reads 0, irq is low and txValid is low.
- R2: Each transmit window word reads back what was written, except the length word, which keeps only bits 3:0. Committed frames leave the pop port in commit order. Transmit control bits 3:1 hold the count of unsent entries and bit 0 is the enable.
- R3: When the transmit queue already holds 4 entries and no pop happens in the same cycle, a commit is ignored and neither the count nor the queue contents change.
- R4: Only a write of exactly 0xFF in bits 7:0 of a pointer register commits or releases an entry. Any other value has no effect.
- R5: A push stores the frame. The receive window shows the oldest stored frame, or reads zero when the queue is empty. Receive control bit 7 reads 1 when the queue is empty, bit 0 is the enable, and a release brings the next frame into the window.
- R6: A release while the receive queue is empty is ignored and moves no pointer, so the next pushed frame is the one shown in the window.
- R7: A push into a full receive queue with receive control bit 1 set replaces the newest stored frame, leaves the count at 4 and sets flag bit 5 (overrun).
- R8: A push into a full receive queue with receive control bit 1 clear is dropped, leaves the stored frames unchanged and sets flag bit 5.
- R9: Flag bit 3 sets on every pop and bit 4 sets on every stored push. A write to the flag register keeps each flag whose written bit is 1 and clears each flag whose written bit is 0. A flag that sets in the same cycle as a clear stays set.
- R10: irq is high exactly when a flag in bits 5:3 is set and the same bit is set in the enable register (word 12).
- R11: Clearing a queue's enable bit empties that queue at once. While the enable is clear, commits or pushes for that queue are ignored and raise no flag.
- R12: A commit and a pop in the same cycle leave the unsent count unchanged. A push and a release in the same cycle on a full receive queue both take effect and raise no overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostWe | input | 1 | Host register write strobe |
| hostAddr | input | 4 | Host word address |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data for hostAddr (combinational) |
| irq | output | 1 | Interrupt, OR of enabled flags |
| txValid | output | 1 | Transmit queue holds an unsent entry |
| txId | output | 32 | ID word of the oldest unsent entry |
| txLen | output | 4 | Data length code of the oldest unsent entry |
| txData | output | 64 | Data bytes of the oldest unsent entry |
| txPop | input | 1 | Transmitter takes the oldest entry |
| rxPush | input | 1 | Receiver delivers a frame |
| rxId | input | 32 | ID word of the delivered frame |
| rxLen | input | 4 | Data length code of the delivered frame |
| rxData | input | 64 | Data bytes of the delivered frame |
| rxStamp | input | 16 | Timestamp of the delivered frame |

## Verification
Two pairs of events can fall in the same cycle. The first is a host write that clears the flag register while the bus side pops or pushes. The bench drives the clearing write and a receive push on the same clock edge, and the check passes only if the receive flag still reads set afterwards. The second pair is bus-side traffic meeting a host pointer write. The bench commits while popping, and pushes while releasing on a full receive queue. It then judges the unsent count, the absence of the overrun flag and the exact order in which frames drain.

// File: rtl/mbox_fifo_pkg.sv
package mbox_fifo_pkg;

  // One queue entry: identifier word, length code, eight data bytes, timestamp.
  typedef struct packed {
    logic [31:0] id;
    logic [3:0]  len;
    logic [63:0] data;
    logic [15:0] stamp;
  } msg_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic txIdWr;
    logic txLenWr;
    logic txLoWr;
    logic txHiWr;
    logic txCommit;
    logic rxStore;
  } strobe_t;

  localparam logic [3:0] A_TX_ID  = 4'd0;
  localparam logic [3:0] A_TX_LEN = 4'd1;
  localparam logic [3:0] A_TX_LO  = 4'd2;
  localparam logic [3:0] A_TX_HI  = 4'd3;
  localparam logic [3:0] A_RX_ID  = 4'd4;
  localparam logic [3:0] A_RX_LEN = 4'd5;
  localparam logic [3:0] A_RX_LO  = 4'd6;
  localparam logic [3:0] A_RX_HI  = 4'd7;
  localparam logic [3:0] A_TXCTL  = 4'd8;
  localparam logic [3:0] A_RXCTL  = 4'd9;
  localparam logic [3:0] A_TXPTR  = 4'd10;
  localparam logic [3:0] A_RXPTR  = 4'd11;
  localparam logic [3:0] A_IEN    = 4'd12;
  localparam logic [3:0] A_ISTAT  = 4'd13;

  localparam logic [7:0] ADV_KEY = 8'hFF;

endpackage

// File: rtl/mbox_fifo_ctrl.sv
module mbox_fifo_ctrl
  import mbox_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostWe,
  input  logic [3:0]       hostAddr,
  input  logic [31:0]      hostWdata,
  input  logic             txPop,
  input  logic             rxPush,
  output strobe_t          strb,
  output logic [PTR_W-1:0] txWrPtr,
  output logic [PTR_W-1:0] txRdPtr,
  output logic [PTR_W-1:0] rxStoreIdx,
  output logic [PTR_W-1:0] rxRdPtr,
  output logic [CNT_W-1:0] txCount,
  output logic [CNT_W-1:0] rxCount,
  output logic             txEn,
  output logic             rxEn,
  output logic             lostMode,
  output logic [2:0]       flags,
  output logic [2:0]       ien,
  output logic             txValid,
  output logic             irq
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  function automatic logic [PTR_W-1:0] ptrNext(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptrPrev(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH - 1) : p - 1'b1;
  endfunction

  logic [PTR_W-1:0] rxWrPtr;
  logic txPtrWr, rxPtrWr, txCtlWr, rxCtlWr, ienWr, istatWr;
  logic txPopOk, txCommitOk, txFlush;
  logic rxRelOk, rxFullNow, rxStoreNew, rxOverwrite, rxOverrun, rxFlush;
  logic [2:0] setEv;

  assign txPtrWr = hostWe && hostAddr == A_TXPTR && hostWdata[7:0] == ADV_KEY;
  assign rxPtrWr = hostWe && hostAddr == A_RXPTR && hostWdata[7:0] == ADV_KEY;
  assign txCtlWr = hostWe && hostAddr == A_TXCTL;
  assign rxCtlWr = hostWe && hostAddr == A_RXCTL;
  assign ienWr   = hostWe && hostAddr == A_IEN;
  assign istatWr = hostWe && hostAddr == A_ISTAT;

  // Transmit side
  assign txValid    = txCount != '0;
  assign txPopOk    = txPop && txValid;
  assign txCommitOk = txEn && txPtrWr && (txCount != FULL || txPopOk);
  assign txFlush    = !txEn || (txCtlWr && !hostWdata[0]);

  // Receive side
  assign rxRelOk     = rxEn && rxPtrWr && rxCount != '0;
  assign rxFullNow   = rxCount == FULL && !rxRelOk;
  assign rxStoreNew  = rxEn && rxPush && !rxFullNow;
  assign rxOverrun   = rxEn && rxPush && rxFullNow;
  assign rxOverwrite = rxOverrun && lostMode;
  assign rxFlush     = !rxEn || (rxCtlWr && !hostWdata[0]);
  assign rxStoreIdx  = rxStoreNew ? rxWrPtr : ptrPrev(rxWrPtr);

  always_comb begin
    strb          = '0;
    strb.txIdWr   = hostWe && hostAddr == A_TX_ID;
    strb.txLenWr  = hostWe && hostAddr == A_TX_LEN;
    strb.txLoWr   = hostWe && hostAddr == A_TX_LO;
    strb.txHiWr   = hostWe && hostAddr == A_TX_HI;
    strb.txCommit = txCommitOk;
    strb.rxStore  = rxStoreNew || rxOverwrite;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEn     <= 1'b0;
      rxEn     <= 1'b0;
      lostMode <= 1'b0;
      ien      <= '0;
    end else begin
      if (txCtlWr) txEn <= hostWdata[0];
      if (rxCtlWr) begin
        rxEn     <= hostWdata[0];
        lostMode <= hostWdata[1];
      end
      if (ienWr) ien <= hostWdata[5:3];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txWrPtr <= '0;
      txRdPtr <= '0;
      txCount <= '0;
    end else if (txFlush) begin
      txWrPtr <= '0;
      txRdPtr <= '0;
      txCount <= '0;
    end else begin
      if (txCommitOk) txWrPtr <= ptrNext(txWrPtr);
      if (txPopOk)    txRdPtr <= ptrNext(txRdPtr);
      txCount <= txCount + CNT_W'(txCommitOk) - CNT_W'(txPopOk);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxWrPtr <= '0;
      rxRdPtr <= '0;
      rxCount <= '0;
    end else if (rxFlush) begin
      rxWrPtr <= '0;
      rxRdPtr <= '0;
      rxCount <= '0;
    end else begin
      if (rxStoreNew) rxWrPtr <= ptrNext(rxWrPtr);
      if (rxRelOk)    rxRdPtr <= ptrNext(rxRdPtr);
      rxCount <= rxCount + CNT_W'(rxStoreNew) - CNT_W'(rxRelOk);
    end
  end

  // Sticky flags: [0] transmit pop, [1] receive store, [2] overrun
  assign setEv = {rxOverrun, strb.rxStore, txPopOk};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else if (istatWr) flags <= (flags & hostWdata[5:3]) | setEv;
    else flags <= flags | setEv;
  end

  assign irq = |(flags & ien);

endmodule

// File: rtl/mbox_fifo_data.sv
module mbox_fifo_data
  import mbox_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [3:0]       hostAddr,
  input  logic [31:0]      hostWdata,
  input  logic [PTR_W-1:0] txWrPtr,
  input  logic [PTR_W-1:0] txRdPtr,
  input  logic [PTR_W-1:0] rxStoreIdx,
  input  logic [PTR_W-1:0] rxRdPtr,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  input  logic             txEn,
  input  logic             rxEn,
  input  logic             lostMode,
  input  logic [2:0]       flags,
  input  logic [2:0]       ien,
  input  msg_t             rxIn,
  output msg_t             txHead,
  output logic [31:0]      hostRdata
);

  msg_t txWin;
  msg_t txMem [DEPTH];
  msg_t rxMem [DEPTH];
  msg_t rxHead;
  logic [2:0] unsent;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txWin <= '0;
    else begin
      if (strb.txIdWr)  txWin.id          <= hostWdata;
      if (strb.txLenWr) txWin.len         <= hostWdata[3:0];
      if (strb.txLoWr)  txWin.data[31:0]  <= hostWdata;
      if (strb.txHiWr)  txWin.data[63:32] <= hostWdata;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strb.txCommit && txWrPtr == PTR_W'(g)) txMem[g] <= txWin;
      if (strb.rxStore && rxStoreIdx == PTR_W'(g)) rxMem[g] <= rxIn;
    end
  end

  assign txHead = txMem[txRdPtr];
  assign rxHead = (rxCount == '0) ? '0 : rxMem[rxRdPtr];
  assign unsent = 3'(txCount);

  always_comb begin
    hostRdata = '0;
    case (hostAddr)
      A_TX_ID:  hostRdata = txWin.id;
      A_TX_LEN: hostRdata = {28'd0, txWin.len};
      A_TX_LO:  hostRdata = txWin.data[31:0];
      A_TX_HI:  hostRdata = txWin.data[63:32];
      A_RX_ID:  hostRdata = rxHead.id;
      A_RX_LEN: hostRdata = {rxHead.stamp, 12'd0, rxHead.len};
      A_RX_LO:  hostRdata = rxHead.data[31:0];
      A_RX_HI:  hostRdata = rxHead.data[63:32];
      A_TXCTL:  hostRdata = {28'd0, unsent, txEn};
      A_RXCTL:  hostRdata = {24'd0, rxCount == '0, 5'd0, lostMode, rxEn};
      A_IEN:    hostRdata = {26'd0, ien, 3'd0};
      A_ISTAT:  hostRdata = {26'd0, flags, 3'd0};
      default:  hostRdata = '0;
    endcase
  end

endmodule

// File: rtl/mbox_fifo_pair.sv
module mbox_fifo_pair
  import mbox_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWe,
  input  logic [3:0]  hostAddr,
  input  logic [31:0] hostWdata,
  output logic [31:0] hostRdata,
  output logic        irq,
  output logic        txValid,
  output logic [31:0] txId,
  output logic [3:0]  txLen,
  output logic [63:0] txData,
  input  logic        txPop,
  input  logic        rxPush,
  input  logic [31:0] rxId,
  input  logic [3:0]  rxLen,
  input  logic [63:0] rxData,
  input  logic [15:0] rxStamp
);

  strobe_t          strb;
  logic [PTR_W-1:0] txWrPtr, txRdPtr, rxStoreIdx, rxRdPtr;
  logic [CNT_W-1:0] txCount, rxCount;
  logic             txEn, rxEn, lostMode;
  logic [2:0]       flags, ien;
  msg_t             txHead, rxIn;

  assign rxIn = '{id: rxId, len: rxLen, data: rxData, stamp: rxStamp};

  mbox_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk, .rstN, .hostWe, .hostAddr, .hostWdata, .txPop, .rxPush,
    .strb, .txWrPtr, .txRdPtr, .rxStoreIdx, .rxRdPtr, .txCount, .rxCount,
    .txEn, .rxEn, .lostMode, .flags, .ien, .txValid, .irq
  );

  mbox_fifo_data #(.DEPTH(DEPTH)) u_data (
    .clk, .rstN, .strb, .hostAddr, .hostWdata, .txWrPtr, .txRdPtr,
    .rxStoreIdx, .rxRdPtr, .txCount, .rxCount, .txEn, .rxEn, .lostMode,
    .flags, .ien, .rxIn, .txHead, .hostRdata
  );

  assign txId   = txHead.id;
  assign txLen  = txHead.len;
  assign txData = txHead.data;

endmodule

// File: rtl/mbox_fifo_chk.sv
module mbox_fifo_chk
  import mbox_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             hostWe,
  input logic [3:0]       hostAddr,
  input logic [31:0]      hostWdata,
  input logic             txPop,
  input logic             txValid,
  input logic             rxPush,
  input logic [CNT_W-1:0] txCount,
  input logic [CNT_W-1:0] rxCount,
  input logic             txEn,
  input logic             rxEn,
  input logic [2:0]       flags
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  p_tx_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    txCount <= FULL);

  p_full_commit_r3: assert property (@(posedge clk) disable iff (!rstN)
    hostWe && hostAddr == A_TXPTR && hostWdata[7:0] == ADV_KEY &&
    txCount == FULL && !(txPop && txValid) |=> txCount == FULL);

  p_empty_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    hostWe && hostAddr == A_RXPTR && rxCount == '0 && !rxPush |=> rxCount == '0);

  p_overrun_r8: assert property (@(posedge clk) disable iff (!rstN)
    rxEn && rxPush && rxCount == FULL && !(hostWe && hostAddr == A_RXPTR)
    |=> flags[2]);

  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    hostWe && hostAddr == A_ISTAT && !hostWdata[3] && !(txPop && txValid)
    |=> !flags[0]);

  p_tx_off_empty_r11: assert property (@(posedge clk) disable iff (!rstN)
    !txEn |-> txCount == '0);

  p_rx_off_empty_r11: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |-> rxCount == '0);

endmodule

bind mbox_fifo_pair mbox_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostAddr(hostAddr),
  .hostWdata(hostWdata), .txPop(txPop), .txValid(txValid), .rxPush(rxPush),
  .txCount(txCount), .rxCount(rxCount), .txEn(txEn), .rxEn(rxEn),
  .flags(flags)
);

// File: tb/test_mbox_fifo_pair.sv
module test_mbox_fifo_pair;
  import mbox_fifo_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWe = 1'b0;
  logic [3:0]  hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic        irq, txValid;
  logic [31:0] txId;
  logic [3:0]  txLen;
  logic [63:0] txData;
  logic        txPop = 1'b0;
  logic        rxPush = 1'b0;
  logic [31:0] rxId = '0;
  logic [3:0]  rxLen = '0;
  logic [63:0] rxData = '0;
  logic [15:0] rxStamp = '0;

  int nChecks = 0;
  int nErr = 0;

  always #2 clk = ~clk;

  mbox_fifo_pair #(.DEPTH(4)) i_mbox_fifo_pair (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    hostAddr = a;
    #1;
    check(tag, hostRdata, exp);
  endtask

  task automatic push(input logic [31:0] id, input logic [3:0] len,
                      input logic [63:0] d, input logic [15:0] st);
    @(negedge clk);
    rxPush = 1'b1; rxId = id; rxLen = len; rxData = d; rxStamp = st;
    @(negedge clk);
    rxPush = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    txPop = 1'b1;
    @(negedge clk);
    txPop = 1'b0;
  endtask

  task automatic commitId(input logic [31:0] id);
    wr(A_TX_ID, id);
    wr(A_TXPTR, 32'hFF);
  endtask

  task automatic t_reset();
    rdChk("R1 txctl", A_TXCTL, 32'h0);
    rdChk("R1 rxctl", A_RXCTL, 32'h80);
    rdChk("R1 istat", A_ISTAT, 32'h0);
    check("R1 irq", irq, 1'b0);
    check("R1 txValid", txValid, 1'b0);
  endtask

  task automatic t_tx_basic();
    wr(A_TXCTL, 32'h1);
    wr(A_TX_ID, 32'h8000_1234);
    wr(A_TX_LEN, 32'h15);
    wr(A_TX_LO, 32'h4433_2211);
    wr(A_TX_HI, 32'h8877_6655);
    rdChk("R2 win id", A_TX_ID, 32'h8000_1234);
    rdChk("R2 win len", A_TX_LEN, 32'h5);
    rdChk("R2 win lo", A_TX_LO, 32'h4433_2211);
    rdChk("R2 win hi", A_TX_HI, 32'h8877_6655);
    wr(A_TXPTR, 32'h7F);
    rdChk("R4 non-key commit", A_TXCTL, 32'h1);
    check("R4 txValid", txValid, 1'b0);
    wr(A_TXPTR, 32'hFF);
    rdChk("R2 unsent 1", A_TXCTL, 32'h3);
    wr(A_TX_ID, 32'h048C_0000);
    wr(A_TXPTR, 32'hFF);
    rdChk("R2 unsent 2", A_TXCTL, 32'h5);
    check("R2 head id", txId, 64'h8000_1234);
    check("R2 head len", txLen, 64'h5);
    check("R2 head data", txData, 64'h8877_6655_4433_2211);
    pop();
    check("R2 second id", txId, 64'h048C_0000);
    rdChk("R9 tx flag", A_ISTAT, 32'h08);
    pop();
    check("R2 drained", txValid, 1'b0);
    rdChk("R2 unsent 0", A_TXCTL, 32'h1);
    wr(A_ISTAT, 32'h0);
    rdChk("R9 cleared", A_ISTAT, 32'h0);
  endtask

  task automatic t_tx_full();
    for (int k = 0; k < 4; k++) commitId(32'h100 + k);
    rdChk("R3 full", A_TXCTL, 32'h9);
    commitId(32'h199);
    rdChk("R3 still 4", A_TXCTL, 32'h9);
    for (int k = 0; k < 4; k++) begin
      check("R3 order", txId, 64'h100 + k);
      pop();
    end
    check("R3 empty after", txValid, 1'b0);
  endtask

  task automatic t_tx_same();
    commitId(32'h200);
    commitId(32'h201);
    wr(A_TX_ID, 32'h202);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = A_TXPTR; hostWdata = 32'hFF; txPop = 1'b1;
    @(negedge clk);
    hostWe = 1'b0; txPop = 1'b0;
    rdChk("R12 commit+pop count", A_TXCTL, 32'h5);
    check("R12 head", txId, 64'h201);
    pop();
    check("R12 appended", txId, 64'h202);
    pop();
    wr(A_ISTAT, 32'h0);
  endtask

  task automatic t_rx_basic();
    wr(A_RXCTL, 32'h1);
    rdChk("R5 enabled empty", A_RXCTL, 32'h81);
    wr(A_RXPTR, 32'hFF);
    rdChk("R6 release empty", A_RXCTL, 32'h81);
    push(32'hA, 4'h8, 64'h0102_0304_0506_0708, 16'hBEEF);
    push(32'hB, 4'h2, 64'h0, 16'h0001);
    rdChk("R5 not empty", A_RXCTL, 32'h01);
    rdChk("R5 id A", A_RX_ID, 32'hA);
    rdChk("R5 len A", A_RX_LEN, 32'hBEEF_0008);
    rdChk("R5 lo A", A_RX_LO, 32'h0506_0708);
    rdChk("R5 hi A", A_RX_HI, 32'h0102_0304);
    rdChk("R9 rx flag", A_ISTAT, 32'h10);
    wr(A_RXPTR, 32'h12);
    rdChk("R4 non-key release", A_RX_ID, 32'hA);
    wr(A_RXPTR, 32'hFF);
    rdChk("R5 id B", A_RX_ID, 32'hB);
    wr(A_RXPTR, 32'hFF);
    rdChk("R5 empty again", A_RXCTL, 32'h81);
    rdChk("R5 empty window", A_RX_ID, 32'h0);
    wr(A_RXPTR, 32'hFF);
    push(32'hC, 4'h1, 64'h0, 16'h0);
    rdChk("R6 pointer kept", A_RX_ID, 32'hC);
    wr(A_RXPTR, 32'hFF);
    wr(A_ISTAT, 32'h0);
  endtask

  task automatic t_rx_overrun();
    for (int k = 0; k < 5; k++) push(32'h10 + k, 4'h0, 64'h0, 16'h0);
    rdChk("R8 overrun flag", A_ISTAT, 32'h30);
    for (int k = 0; k < 4; k++) begin
      rdChk("R8 kept frames", A_RX_ID, 32'h10 + k);
      wr(A_RXPTR, 32'hFF);
    end
    rdChk("R8 drained", A_RXCTL, 32'h81);
    wr(A_ISTAT, 32'h0);
    wr(A_RXCTL, 32'h3);
    for (int k = 0; k < 5; k++) push(32'h20 + k, 4'h0, 64'h0, 16'h0);
    rdChk("R7 overrun flag", A_ISTAT, 32'h30);
    rdChk("R7 count held", A_RXCTL, 32'h03);
    for (int k = 0; k < 4; k++) begin
      rdChk("R7 newest replaced", A_RX_ID, (k == 3) ? 32'h24 : 32'h20 + k);
      wr(A_RXPTR, 32'hFF);
    end
    rdChk("R7 drained", A_RXCTL, 32'h83);
    wr(A_RXCTL, 32'h1);
    wr(A_ISTAT, 32'h0);
  endtask

  task automatic t_rx_same();
    for (int k = 0; k < 4; k++) push(32'h30 + k, 4'h0, 64'h0, 16'h0);
    wr(A_ISTAT, 32'h0);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = A_RXPTR; hostWdata = 32'hFF;
    rxPush = 1'b1; rxId = 32'h3F;
    @(negedge clk);
    hostWe = 1'b0; rxPush = 1'b0;
    rdChk("R12 no overrun", A_ISTAT, 32'h10);
    for (int k = 0; k < 4; k++) begin
      rdChk("R12 order", A_RX_ID, (k == 3) ? 32'h3F : 32'h31 + k);
      wr(A_RXPTR, 32'hFF);
    end
    rdChk("R12 drained", A_RXCTL, 32'h81);
    wr(A_ISTAT, 32'h0);
  endtask

  task automatic t_flags();
    wr(A_IEN, 32'h0);
    push(32'h40, 4'h0, 64'h0, 16'h0);
    rdChk("R9 rx set", A_ISTAT, 32'h10);
    check("R10 masked", irq, 1'b0);
    wr(A_IEN, 32'h08);
    check("R10 other enable", irq, 1'b0);
    wr(A_IEN, 32'h10);
    check("R10 enabled", irq, 1'b1);
    wr(A_ISTAT, 32'h10);
    rdChk("R9 write 1 keeps", A_ISTAT, 32'h10);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = A_ISTAT; hostWdata = 32'h0;
    rxPush = 1'b1; rxId = 32'h41;
    @(negedge clk);
    hostWe = 1'b0; rxPush = 1'b0;
    rdChk("R9 set wins", A_ISTAT, 32'h10);
    wr(A_ISTAT, 32'h0);
    rdChk("R9 clear", A_ISTAT, 32'h0);
    check("R10 low", irq, 1'b0);
    wr(A_RXPTR, 32'hFF);
    wr(A_RXPTR, 32'hFF);
    wr(A_IEN, 32'h0);
  endtask

  task automatic t_disable();
    commitId(32'h50);
    commitId(32'h51);
    wr(A_TXCTL, 32'h0);
    rdChk("R11 tx flushed", A_TXCTL, 32'h0);
    check("R11 txValid", txValid, 1'b0);
    commitId(32'h52);
    rdChk("R11 tx commit ignored", A_TXCTL, 32'h0);
    wr(A_ISTAT, 32'h0);
    push(32'h60, 4'h0, 64'h0, 16'h0);
    wr(A_RXCTL, 32'h0);
    rdChk("R11 rx flushed", A_RXCTL, 32'h80);
    push(32'h61, 4'h0, 64'h0, 16'h0);
    rdChk("R11 rx push ignored", A_RXCTL, 32'h80);
    wr(A_ISTAT, 32'h10);
    wr(A_ISTAT, 32'h0);
    push(32'h62, 4'h0, 64'h0, 16'h0);
    rdChk("R11 no flag", A_ISTAT, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_basic();
    t_tx_full();
    t_tx_same();
    t_rx_basic();
    t_rx_overrun();
    t_rx_same();
    t_flags();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    #800000;
    nChecks++;
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

endmodule